// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus in front of a 512-byte on-chip store. The bus clock and data lines come in from pads. A faster system clock samples them through synchronizers, and the block decodes bus events from the sampled edges. The block never drives the clock line. It pulls the data line low through a single enable output, which the pad turns into an open-drain driver.

A master first sends a select byte. This byte carries a fixed type code, two bits that must match the strap pins, the high bit of the 9-bit address, and the transfer direction. For a write, the next byte is the low eight address bits, and every byte after that is stored. For a read, bytes come from the current address pointer. The pointer advances after each byte and wraps from the last location back to the first.

The store is a plain register array that commits a byte in one cycle. Every byte the slave accepts is therefore acknowledged at once, and the slave never asks the master to retry.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset the slave leaves the data line released, with `sda_pull_o` at 0, and waits for a start condition.
- R2: The select byte is received MSB first. Bits 7..4 must be 1010 and bits 3..2 must equal {`addr_pin_hi`, `addr_pin_lo`). Bit 1 is the page bit, the address bit 8. Bit 0 is the direction, where 1 means read. A matching select byte is acknowledged by pulling the line low during the ninth clock.
- R3: A select byte that fails the match is not acknowledged. The slave then ignores the bus until the next start: later bytes get no acknowledge and do not change the store.
- R4: In a write, the byte after the select byte is the word address, bits 7..0. The stored location is {page bit, word address}. Each following data byte is written there and acknowledged.
- R5: The address pointer advances by one after each byte is written or sent. It wraps from 511 to 0.
- R6: A read starts at the current pointer. The page bit of a read select byte has no effect on the address.
- R7: In a read, the slave drives each byte MSB first, pulling low only for 0 bits. It releases the line in the acknowledge slot. A master acknowledge (line low) continues the read with the next byte.
- R8: A master no-acknowledge (line high) ends the read. The slave drives nothing until the next start or stop, and the pointer does not move any further.
- R9: A start condition at any point, including partway through a byte, restarts select-byte reception without storing the partial byte. A stop returns the slave to idle with the line released.
- R10: `sda_pull_o` changes only while the sampled bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Bus clock from the pad |
| sda_i | input | 1 | Bus data as seen on the pad |
| addr_pin_hi | input | 1 | Strap pin compared with select bit 3 |
| addr_pin_lo | input | 1 | Strap pin compared with select bit 2 |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The end of a data byte commits the write and advances the pointer in the same cycle. The bench provokes this at the top of the store, where the pointer wraps from 511 to 0 during the same commit, and judges it by reading the four bytes back across the boundary. In a second case, a start condition arrives while the byte shifter holds half a data byte. The bench checks that the start wins by confirming that the addressed location still holds its earlier value.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DACK,
        ST_WADDR,
        ST_WACK,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tw_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    localparam int MSB = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_s;

    sync_s q, d;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_pipe[MSB];
        d.sda_prev = q.sda_pipe[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_o      = q.scl_pipe[MSB];
    assign sda_o      = q.sda_pipe[MSB];
    assign scl_rise_o = scl_o & ~q.scl_prev;
    assign scl_fall_o = ~scl_o & q.scl_prev;
    assign start_o    = scl_o & q.scl_prev & q.sda_prev & ~sda_o;
    assign stop_o     = scl_o & q.scl_prev & ~q.sda_prev & sda_o;

endmodule

// File: rtl/tw_mem.sv
module tw_mem #(
    parameter int DW = 8,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cells_q[addr_i] <= wdata_i;
    end

    assign rdata_o = cells_q[addr_i];

endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
    import tw_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = DW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          pin_hi,
    input  logic          pin_lo,
    input  logic [DW-1:0] rdata_i,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          pull_o
);

    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL = CW'(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    typedef struct packed {
        tw_state_e     st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic [AW-1:0] ptr;
        logic          page;
        logic          rw;
        logic          pull;
        logic          mack;
    } ctrl_s;

    ctrl_s q, d;
    logic  dev_match;

    assign dev_match = (q.sh[DW-1:DW-4] == DEV_TYPE) && (q.sh[3:2] == {pin_hi, pin_lo});

    always_comb begin
        d    = q;
        we_o = 1'b0;
        if (start_det) begin
            d.st   = ST_DEV;
            d.cnt  = '0;
            d.pull = 1'b0;
        end else if (stop_det) begin
            d.st   = ST_IDLE;
            d.cnt  = '0;
            d.pull = 1'b0;
        end else begin
            case (q.st)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && q.cnt < FULL) begin
                        d.sh  = {q.sh[DW-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == FULL) begin
                        d.cnt = '0;
                        if (q.st == ST_DEV) begin
                            if (dev_match) begin
                                d.page = q.sh[1];
                                d.rw   = q.sh[0];
                                d.pull = 1'b1;
                                d.st   = ST_DACK;
                            end else begin
                                d.st = ST_IGNORE;
                            end
                        end else if (q.st == ST_WADDR) begin
                            d.ptr  = {q.page, q.sh};
                            d.pull = 1'b1;
                            d.st   = ST_WACK;
                        end else begin
                            we_o   = 1'b1;
                            d.ptr  = q.ptr + 1'b1;
                            d.pull = 1'b1;
                            d.st   = ST_WACK;
                        end
                    end
                end
                ST_DACK: begin
                    if (scl_fall) begin
                        if (q.rw) begin
                            d.sh   = rdata_i;
                            d.ptr  = q.ptr + 1'b1;
                            d.pull = ~rdata_i[DW-1];
                            d.cnt  = '0;
                            d.st   = ST_RDATA;
                        end else begin
                            d.pull = 1'b0;
                            d.st   = ST_WADDR;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        d.pull = 1'b0;
                        d.st   = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST) begin
                            d.pull = 1'b0;
                            d.st   = ST_RACK;
                        end else begin
                            d.cnt  = q.cnt + 1'b1;
                            d.sh   = {q.sh[DW-2:0], 1'b0};
                            d.pull = ~q.sh[DW-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.sh   = rdata_i;
                            d.ptr  = q.ptr + 1'b1;
                            d.pull = ~rdata_i[DW-1];
                            d.cnt  = '0;
                            d.st   = ST_RDATA;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign addr_o  = q.ptr;
    assign wdata_o = q.sh;
    assign pull_o  = q.pull;

    // The data drive may only move while the bus clock is low.
    assert_sda_move_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pull != $past(q.pull)) |-> !scl_s);

    // Writing the last location sends the pointer back to zero.
    assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && q.ptr == {AW{1'b1}} && !start_det && !stop_det) |=> (q.ptr == '0));

    // An unselected or finished slave keeps the line released.
    assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IGNORE) |-> !q.pull);

    // A stop leaves the slave idle and released.
    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.st == ST_IDLE && !q.pull));

    // A start always restarts select-byte reception.
    assert_start_dev_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (q.st == ST_DEV && q.cnt == '0));

    // A master no-acknowledge ends the read.
    assert_nack_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RACK && scl_fall && !q.mack && !start_det && !stop_det) |=> (q.st == ST_IGNORE));

endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_pin_hi,
    input  logic addr_pin_lo,
    output logic sda_pull_o
);

    localparam int AW = DW + 1;

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    tw_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .pin_hi    (addr_pin_hi),
        .pin_lo    (addr_pin_lo),
        .rdata_i   (mem_rdata),
        .we_o      (mem_we),
        .addr_o    (mem_addr),
        .wdata_o   (mem_wdata),
        .pull_o    (sda_pull_o)
    );

    tw_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .addr_i  (mem_addr),
        .wdata_i (mem_wdata),
        .rdata_o (mem_rdata)
    );

endmodule

// File: tb/tw_mem_slave_tb.sv
module tw_mem_slave_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic pin_hi = 1'b1;
    logic pin_lo = 1'b0;
    logic sda_pull;
    wire  sda_line = m_sda & ~sda_pull;

    int checks = 0;
    int errors = 0;
    bit unstable = 1'b0;

    always #10 clk = ~clk;

    tw_mem_slave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .addr_pin_hi (pin_hi),
        .addr_pin_lo (pin_lo),
        .sda_pull_o  (sda_pull)
    );

    // {page, word address, data}
    localparam logic [16:0] VEC [8] = '{
        {1'b0, 8'h00, 8'h5A}, {1'b1, 8'h00, 8'hA5},
        {1'b0, 8'h33, 8'hC3}, {1'b1, 8'h33, 8'h3C},
        {1'b0, 8'hFF, 8'h01}, {1'b1, 8'h80, 8'hFE},
        {1'b0, 8'h7E, 8'h00}, {1'b1, 8'hC1, 8'hFF}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sel(input logic page, input logic rd);
        return {4'b1010, pin_hi, pin_lo, page, rd};
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; tick(8);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b0; tick(8);
        m_scl = 1'b0; tick(8);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(8);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b1; tick(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(8);
            m_scl = 1'b1; tick(8);
            m_scl = 1'b0;
        end
        m_sda = 1'b1; tick(8);
        m_scl = 1'b1; tick(4);
        ack = ~sda_line; tick(4);
        m_scl = 1'b0; tick(8);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic early;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(8);
            m_scl = 1'b1; tick(2);
            early = sda_line; tick(4);
            b[i] = sda_line;
            if (early != b[i]) unstable = 1'b1;
            tick(2);
            m_scl = 1'b0;
        end
        tick(2);
        m_sda = ~mack; tick(6);
        m_scl = 1'b1; tick(8);
        m_scl = 1'b0; tick(4);
        m_sda = 1'b1; tick(4);
    endtask

    task automatic random_read(input logic page, input logic [7:0] wa, output logic [7:0] b,
                               output logic all_ack);
        logic a0, a1, a2;
        bus_start();
        send_byte(sel(page, 1'b0), a0);
        send_byte(wa, a1);
        bus_start();
        send_byte(sel(page, 1'b1), a2);
        recv_byte(1'b0, b);
        bus_stop();
        all_ack = a0 & a1 & a2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic a0, a1, a2, a3, ok;
        logic [7:0] rb;
        logic [7:0] seq [4];

        tick(5);
        check(sda_pull == 1'b0, "R1 reset release", sda_pull, 0);
        rst_n = 1'b1;
        tick(5);
        check(sda_pull == 1'b0, "R1 idle release", sda_pull, 0);

        // R4: write each vector, then read it back at random
        foreach (VEC[i]) begin
            bus_start();
            send_byte(sel(VEC[i][16], 1'b0), a0);
            send_byte(VEC[i][15:8], a1);
            send_byte(VEC[i][7:0], a2);
            bus_stop();
            check(a0 & a1 & a2, "R4 write acks", {a0, a1, a2}, 7);
        end
        foreach (VEC[i]) begin
            random_read(VEC[i][16], VEC[i][15:8], rb, ok);
            check(ok && rb == VEC[i][7:0], "R4 R2 readback", rb, VEC[i][7:0]);
        end

        // R2: wrong fixed type bits get no acknowledge
        bus_start();
        send_byte({4'b1011, pin_hi, pin_lo, 2'b00}, a0);
        bus_stop();
        check(!a0, "R2 type mismatch nack", a0, 0);

        // R3: wrong strap bits, then bytes that must be ignored
        bus_start();
        send_byte({4'b1010, ~pin_hi, pin_lo, 1'b0, 1'b0}, a0);
        send_byte(8'h33, a1);
        send_byte(8'h99, a2);
        bus_stop();
        check(!a0 && !a1 && !a2, "R3 no acks", {a0, a1, a2}, 0);
        random_read(1'b0, 8'h33, rb, ok);
        check(rb == 8'hC3, "R3 store untouched", rb, 8'hC3);

        // R5 R7: burst write across the top, burst read back
        bus_start();
        send_byte(sel(1'b1, 1'b0), a0);
        send_byte(8'hFE, a1);
        send_byte(8'h11, a2);
        send_byte(8'h22, a3);
        ok = a0 & a1 & a2 & a3;
        send_byte(8'h33, a2);
        send_byte(8'h44, a3);
        bus_stop();
        check(ok & a2 & a3, "R5 burst acks", ok, 1);
        bus_start();
        send_byte(sel(1'b1, 1'b0), a0);
        send_byte(8'hFE, a1);
        bus_start();
        send_byte(sel(1'b1, 1'b1), a2);
        for (int k = 0; k < 4; k++) recv_byte(k != 3, seq[k]);
        bus_stop();
        check(seq[0] == 8'h11, "R7 burst byte0", seq[0], 8'h11);
        check(seq[1] == 8'h22, "R7 burst byte1", seq[1], 8'h22);
        check(seq[2] == 8'h33, "R5 wrap byte2", seq[2], 8'h33);
        check(seq[3] == 8'h44, "R5 wrap byte3", seq[3], 8'h44);

        // R8: no-acknowledge ends read; R6: current-address read
        bus_start();
        send_byte(sel(1'b0, 1'b0), a0);
        send_byte(8'h20, a1);
        send_byte(8'hA1, a2);
        send_byte(8'hA2, a3);
        bus_stop();
        bus_start();
        send_byte(sel(1'b0, 1'b0), a0);
        send_byte(8'h20, a1);
        bus_start();
        send_byte(sel(1'b0, 1'b1), a2);
        recv_byte(1'b0, rb);
        check(rb == 8'hA1, "R8 first byte", rb, 8'hA1);
        recv_byte(1'b1, rb);
        check(rb == 8'hFF, "R8 silent after nack", rb, 8'hFF);
        bus_stop();
        bus_start();
        send_byte(sel(1'b1, 1'b1), a0);
        recv_byte(1'b0, rb);
        bus_stop();
        check(a0 && rb == 8'hA2, "R6 current pointer", rb, 8'hA2);

        // R9: start in the middle of a data byte leaves the store intact
        bus_start();
        send_byte(sel(1'b1, 1'b0), a0);
        send_byte(8'h00, a1);
        for (int i = 0; i < 4; i++) begin
            m_sda = 1'b0; tick(8);
            m_scl = 1'b1; tick(8);
            m_scl = 1'b0;
        end
        bus_start();
        send_byte(sel(1'b1, 1'b1), a2);
        recv_byte(1'b0, rb);
        bus_stop();
        check(a2 && rb == 8'hA5, "R9 partial byte dropped", rb, 8'hA5);
        tick(4);
        check(sda_pull == 1'b0, "R9 stop releases", sda_pull, 0);

        check(!unstable, "R10 data stable while clock high", unstable, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule